// File: doc/BRIEF.md
# Time-Stamp Capture Unit

This block records the moment an external event occurs. It watches one event input. When an edge of the chosen polarity appears on that input, the block copies the live subsecond, time and date values from the calendar into shadow registers. It then sets an event flag and can raise an interrupt. Software reads the shadow registers, then clears the flag by writing a zero to its bit position.

The event passes through a synchronizer that is paced by the prescaler-output tick. Because of this, the event flag appears only on the second tick after detection. The overflow flag does not wait for the tick. It is set in the cycle after detection whenever a second event arrives while the flag is set or an earlier capture is still waiting to complete. A flag clear that collides with an event never hides that event: both flags end up set.

Top module: `tsc_stamp_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted at a clock edge, `stamp_flag`, `stamp_ovf`, `stamp_irq` and all three captured outputs go to zero.
- R2: `ts_pin` passes through two clock flops. An edge is detected when the second flop differs from its previous value. The detection cycle is the cycle after the clock edge at which the second flop takes the new level. Suppose an event is detected while `stamp_flag` is 0 and no capture is pending. Then, at the clock edge of the second `tick` after the detection cycle, the unit does two things:
  - it loads the values present on `cal_ss`, `cal_time` and `cal_date` into `cap_ss`, `cap_time` and `cap_date`;
  - it sets `stamp_flag` to 1.
- R3: After the first tick that follows detection, `stamp_flag` is still 0. The flag only ever goes to 1 at an edge where `tick` is high.
- R4: With `edge_rise` = 1, only a 0-to-1 change of the synchronized pin is an event. With `edge_rise` = 0, only a 1-to-0 change is an event. A change of the other polarity sets no flag.
- R5: While `ts_en` is 0, no event is detected and any pending capture is discarded. The flags and captured values do not change because of the pin.
- R6: `stamp_irq` is 1 exactly when `stamp_flag` is 1 and `irq_en` is 1.
- R7: `stamp_ovf` is set at the edge that ends the detection cycle of an event detected while `stamp_flag` is 1 or a capture is pending. No tick is needed, so `stamp_ovf` can read 1 while `stamp_flag` is still 0. The unit also sets `stamp_ovf` when a pending capture arrives while `stamp_flag` is already 1. In that case the captured values keep the earlier capture.
- R8: A cycle with `clr_wr` = 1 clears `stamp_flag` if `clr_data[0]` is 0 and clears `stamp_ovf` if `clr_data[1]` is 0. A bit written as 1 leaves its flag unchanged.
- R9: A set always beats a clear that occurs in the same cycle.
  - If a flag clear coincides with the detection cycle of an event while `stamp_flag` is 1, `stamp_ovf` is set. The later capture then finds the flag cleared, so it captures and sets `stamp_flag`, and both flags end up set.
  - If a flag clear coincides with the arrival of a capture while `stamp_flag` is 1, `stamp_flag` stays 1 and the captured values are unchanged.
- R10: The captured values change only at an edge where `stamp_flag` rises, which is an accepted capture. At all other times they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle prescaler-output pulse that paces the synchronizer |
| ts_pin | input | 1 | External event input |
| ts_en | input | 1 | Capture enable |
| edge_rise | input | 1 | Event polarity: 1 rising, 0 falling |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Flag write strobe |
| clr_data | input | 2 | Write data: bit 0 event flag, bit 1 overflow flag; 0 clears |
| cal_ss | input | SS_W | Live subsecond value |
| cal_time | input | TIME_W | Live time value |
| cal_date | input | DATE_W | Live date value |
| cap_ss | output | SS_W | Captured subsecond |
| cap_time | output | TIME_W | Captured time |
| cap_date | output | DATE_W | Captured date |
| stamp_flag | output | 1 | Event flag |
| stamp_ovf | output | 1 | Overflow flag |
| stamp_irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: two pin flops, a two-tick delay and the default field widths. With these values the detection cycle falls exactly three clock edges after a pin change. This lets a flag-clear write be placed precisely on the detection cycle, and also on the arriving tick, to exercise both collision cases. Ticks are issued by hand. This makes it possible to send two events within one tick interval, which shows the overflow flag set while the event flag is still clear.

// File: rtl/tsc_pkg.sv
// Package: shared constants for the time-stamp capture unit.
// Assumes: software clear writes use bit FLAG_BIT for the event flag and
// OVF_BIT for the overflow flag, both active-low (0 clears).
package tsc_pkg;

    localparam int FLAG_BIT = 0;
    localparam int OVF_BIT  = 1;
    localparam int CLR_W    = 2;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/tsc_pin_sync.sv
// Module: tsc_pin_sync
// Brings the event pin into the clock domain through SYNC_STAGES flops and
// detects an edge of the selected polarity on the last stage.
// Assumes: SYNC_STAGES >= 1; the detect pulse is one clock cycle wide.
module tsc_pin_sync
    import tsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic enable,
    input  logic edge_rise,
    output logic detect
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   level;
    logic                   rise_seen;
    logic                   fall_seen;
    edge_mode_e             mode;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin;
    end

    // Remaining stages, one per generate iteration.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign level = chain_q[SYNC_STAGES-1];

    // History flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Polarity decode and gated detect.
    always_comb begin
        mode      = edge_mode_e'(edge_rise);
        rise_seen = level & ~prev_q;
        fall_seen = ~level & prev_q;
        detect    = enable & ((mode == EDGE_RISE) ? rise_seen : fall_seen);
    end

endmodule

// File: rtl/tsc_tick_pipe.sv
// Module: tsc_tick_pipe
// Delays a detected event by DELAY_TICKS prescaler ticks. Events detected
// between ticks merge into the first slot. Reports whether any event is in
// flight and when one arrives.
// Assumes: DELAY_TICKS >= 1; tick is a one-cycle pulse.
module tsc_tick_pipe #(
    parameter int DELAY_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic detect,
    output logic pending,
    output logic arrive
);

    localparam int LAST = DELAY_TICKS - 1;

    logic [DELAY_TICKS-1:0] slot_q;

    // Entry slot: loads on a tick, otherwise accumulates detections.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) slot_q[0] <= 1'b0;
        else if (tick)         slot_q[0] <= detect;
        else                   slot_q[0] <= slot_q[0] | detect;
    end

    // Later slots advance on each tick.
    for (genvar g = 1; g < DELAY_TICKS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || !enable) slot_q[g] <= 1'b0;
            else if (tick)         slot_q[g] <= slot_q[g-1];
        end
    end

    // Status toward the flag logic.
    always_comb begin
        pending = |slot_q;
        arrive  = tick & enable & slot_q[LAST];
    end

endmodule

// File: rtl/tsc_flag_ctrl.sv
// Module: tsc_flag_ctrl
// Holds the event and overflow flags, applies software clears (set beats
// clear), decides whether an arriving event is captured, and forms the
// interrupt.
// Assumes: detect, pending and arrive come from the same clock domain.
module tsc_flag_ctrl
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect,
    input  logic             pending,
    input  logic             arrive,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_data,
    input  logic             irq_en,
    output logic             load,
    output logic             flag,
    output logic             ovf,
    output logic             irq
);

    logic flag_q;
    logic ovf_q;
    logic flag_set;
    logic flag_clr;
    logic ovf_set;
    logic ovf_clr;

    // Set and clear conditions.
    always_comb begin
        flag_set = arrive;
        flag_clr = clr_wr & ~clr_data[FLAG_BIT];
        ovf_set  = (detect & (flag_q | pending)) | (arrive & flag_q);
        ovf_clr  = clr_wr & ~clr_data[OVF_BIT];
        load     = arrive & ~flag_q;
    end

    // Event flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Overflow flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_set) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    // Outputs.
    always_comb begin
        flag = flag_q;
        ovf  = ovf_q;
        irq  = flag_q & irq_en;
    end

endmodule

// File: rtl/tsc_shadow_regs.sv
// Module: tsc_shadow_regs
// Shadow register that loads the calendar snapshot on an accepted capture
// and holds it otherwise.
// Assumes: load is one cycle wide.
module tsc_shadow_regs #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_r;

    // Snapshot storage.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (load) q_r <= d;
    end

    assign q = q_r;

endmodule

// File: rtl/tsc_stamp_unit.sv
// Module: tsc_stamp_unit (top)
// Time-stamp capture: pin synchronizer, tick-paced delay, flag control and
// shadow registers for the subsecond, time and date fields.
// Assumes: tick is a one-cycle pulse in the clk domain; calendar inputs are
// stable around a tick.
module tsc_stamp_unit
    import tsc_pkg::*;
#(
    parameter int SS_W        = 16,
    parameter int TIME_W      = 22,
    parameter int DATE_W      = 22,
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ts_pin,
    input  logic              ts_en,
    input  logic              edge_rise,
    input  logic              irq_en,
    input  logic              clr_wr,
    input  logic [1:0]        clr_data,
    input  logic [SS_W-1:0]   cal_ss,
    input  logic [TIME_W-1:0] cal_time,
    input  logic [DATE_W-1:0] cal_date,
    output logic [SS_W-1:0]   cap_ss,
    output logic [TIME_W-1:0] cap_time,
    output logic [DATE_W-1:0] cap_date,
    output logic              stamp_flag,
    output logic              stamp_ovf,
    output logic              stamp_irq
);

    localparam int SNAP_W = SS_W + TIME_W + DATE_W;

    logic              det;
    logic              pend;
    logic              arr;
    logic              load;
    logic [SNAP_W-1:0] snap_d;
    logic [SNAP_W-1:0] snap_q;

    tsc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ts_pin),
        .enable    (ts_en),
        .edge_rise (edge_rise),
        .detect    (det)
    );

    tsc_tick_pipe #(.DELAY_TICKS(DELAY_TICKS)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (ts_en),
        .detect  (det),
        .pending (pend),
        .arrive  (arr)
    );

    tsc_flag_ctrl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .detect   (det),
        .pending  (pend),
        .arrive   (arr),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .irq_en   (irq_en),
        .load     (load),
        .flag     (stamp_flag),
        .ovf      (stamp_ovf),
        .irq      (stamp_irq)
    );

    // Pack the live calendar into one snapshot word.
    assign snap_d = {cal_date, cal_time, cal_ss};

    tsc_shadow_regs #(.WIDTH(SNAP_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (snap_d),
        .q     (snap_q)
    );

    // Unpack the captured snapshot.
    assign cap_ss   = snap_q[SS_W-1:0];
    assign cap_time = snap_q[SS_W +: TIME_W];
    assign cap_date = snap_q[SS_W+TIME_W +: DATE_W];

endmodule

// File: rtl/tsc_stamp_checker.sv
// Module: tsc_stamp_checker
// Protocol properties of the capture unit, bound to the top module.
// Assumes: synchronous active-low reset held for at least one edge.
module tsc_stamp_checker #(
    parameter int SS_W   = 16,
    parameter int TIME_W = 22,
    parameter int DATE_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              ts_en,
    input logic              irq_en,
    input logic              clr_wr,
    input logic [1:0]        clr_data,
    input logic [SS_W-1:0]   cap_ss,
    input logic [TIME_W-1:0] cap_time,
    input logic [DATE_W-1:0] cap_date,
    input logic              stamp_flag,
    input logic              stamp_ovf,
    input logic              stamp_irq
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_irq |-> (stamp_flag && irq_en)); // R6

    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_flag && irq_en) |-> stamp_irq); // R6

    AST_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stamp_flag) |-> $past(tick)); // R3

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stamp_flag) |-> $past(ts_en)); // R5

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(cap_ss) || !$stable(cap_time) || !$stable(cap_date))
        |-> $rose(stamp_flag)); // R10

    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_flag && !(clr_wr && !clr_data[0])) |=> stamp_flag); // R8

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_ovf && !(clr_wr && !clr_data[1])) |=> stamp_ovf); // R8

endmodule

bind tsc_stamp_unit tsc_stamp_checker #(
    .SS_W   (SS_W),
    .TIME_W (TIME_W),
    .DATE_W (DATE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ts_en      (ts_en),
    .irq_en     (irq_en),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .cap_ss     (cap_ss),
    .cap_time   (cap_time),
    .cap_date   (cap_date),
    .stamp_flag (stamp_flag),
    .stamp_ovf  (stamp_ovf),
    .stamp_irq  (stamp_irq)
);

// File: tb/tsc_stamp_unit_test.sv
// Directed bench for tsc_stamp_unit: one task per scenario.
module tsc_stamp_unit_test;

    localparam int SS_W   = 16;
    localparam int TIME_W = 22;
    localparam int DATE_W = 22;
    localparam int SNAP_W = SS_W + TIME_W + DATE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              ts_pin = 1'b0;
    logic              ts_en = 1'b0;
    logic              edge_rise = 1'b1;
    logic              irq_en = 1'b0;
    logic              clr_wr = 1'b0;
    logic [1:0]        clr_data = 2'b11;
    logic [SS_W-1:0]   cal_ss = '0;
    logic [TIME_W-1:0] cal_time = '0;
    logic [DATE_W-1:0] cal_date = '0;
    logic [SS_W-1:0]   cap_ss;
    logic [TIME_W-1:0] cap_time;
    logic [DATE_W-1:0] cap_date;
    logic              stamp_flag;
    logic              stamp_ovf;
    logic              stamp_irq;

    int checks = 0;
    int errors = 0;
    logic [SNAP_W-1:0] expect_snap = '0;

    tsc_stamp_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ts_pin     (ts_pin),
        .ts_en      (ts_en),
        .edge_rise  (edge_rise),
        .irq_en     (irq_en),
        .clr_wr     (clr_wr),
        .clr_data   (clr_data),
        .cal_ss     (cal_ss),
        .cal_time   (cal_time),
        .cal_date   (cal_date),
        .cap_ss     (cap_ss),
        .cap_time   (cap_time),
        .cap_date   (cap_date),
        .stamp_flag (stamp_flag),
        .stamp_ovf  (stamp_ovf),
        .stamp_irq  (stamp_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [SNAP_W-1:0] act,
                         input logic [SNAP_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [SNAP_W-1:0] cap_all();
        return {cap_date, cap_time, cap_ss};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cal(input int seed);
        @(negedge clk);
        cal_ss   = SS_W'(seed * 7 + 3);
        cal_time = TIME_W'(seed * 1234 + 5);
        cal_date = DATE_W'(seed * 4321 + 9);
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic drive_pin(input logic v);
        @(negedge clk) ts_pin = v;
        idle(4);
    endtask

    task automatic clear_flags(input logic [1:0] d);
        @(negedge clk) begin clr_wr = 1'b1; clr_data = d; end
        @(negedge clk) begin clr_wr = 1'b0; clr_data = 2'b11; end
    endtask

    // R1: reset state.
    task automatic t_reset();
        check("R1 flag", SNAP_W'(stamp_flag), '0);
        check("R1 ovf", SNAP_W'(stamp_ovf), '0);
        check("R1 irq", SNAP_W'(stamp_irq), '0);
        check("R1 captured", cap_all(), '0);
    endtask

    // R2 R3 R6 R10: basic rising capture.
    task automatic t_basic();
        ts_en = 1'b1; edge_rise = 1'b1; irq_en = 1'b1;
        set_cal(1);
        drive_pin(1'b1);
        tick_once();
        check("R3 flag after one tick", SNAP_W'(stamp_flag), '0);
        expect_snap = {cal_date, cal_time, cal_ss};
        tick_once();
        check("R2 flag", SNAP_W'(stamp_flag), 1);
        check("R2 captured", cap_all(), expect_snap);
        check("R6 irq on", SNAP_W'(stamp_irq), 1);
        irq_en = 1'b0;
        idle(1);
        check("R6 irq masked", SNAP_W'(stamp_irq), '0);
        irq_en = 1'b1;
        drive_pin(1'b0);
        set_cal(2);
        tick_once(); tick_once();
        check("R10 captured held", cap_all(), expect_snap);
        clear_flags(2'b10);
        check("R8 flag cleared", SNAP_W'(stamp_flag), '0);
        check("R6 irq off", SNAP_W'(stamp_irq), '0);
    endtask

    // R4: polarity select.
    task automatic t_polarity();
        edge_rise = 1'b0;
        drive_pin(1'b1);
        tick_once(); tick_once(); tick_once();
        check("R4 rise ignored in fall mode", SNAP_W'(stamp_flag), '0);
        set_cal(3);
        drive_pin(1'b0);
        tick_once();
        expect_snap = {cal_date, cal_time, cal_ss};
        tick_once();
        check("R4 fall captured", SNAP_W'(stamp_flag), 1);
        check("R4 fall value", cap_all(), expect_snap);
        clear_flags(2'b10);
        edge_rise = 1'b1;
    endtask

    // R5: enable gating and discard of pending capture.
    task automatic t_enable();
        ts_en = 1'b0;
        drive_pin(1'b1);
        tick_once(); tick_once(); tick_once();
        check("R5 disabled flag", SNAP_W'(stamp_flag), '0);
        check("R5 disabled ovf", SNAP_W'(stamp_ovf), '0);
        drive_pin(1'b0);
        ts_en = 1'b1;
        drive_pin(1'b1);
        tick_once();
        ts_en = 1'b0;
        idle(2);
        ts_en = 1'b1;
        tick_once(); tick_once(); tick_once();
        check("R5 pending discarded", SNAP_W'(stamp_flag), '0);
        check("R5 captured unchanged", cap_all(), expect_snap);
        drive_pin(1'b0);
    endtask

    // R7 R8: overflow without delay, earlier capture kept.
    task automatic t_overflow();
        set_cal(4);
        drive_pin(1'b1); drive_pin(1'b0);
        check("R7 single event no ovf", SNAP_W'(stamp_ovf), '0);
        drive_pin(1'b1); drive_pin(1'b0);
        check("R7 ovf before flag", SNAP_W'(stamp_ovf), 1);
        check("R7 flag still clear", SNAP_W'(stamp_flag), '0);
        tick_once();
        expect_snap = {cal_date, cal_time, cal_ss};
        tick_once();
        check("R7 merged capture flag", SNAP_W'(stamp_flag), 1);
        check("R7 merged capture value", cap_all(), expect_snap);
        clear_flags(2'b01);
        check("R8 ovf cleared", SNAP_W'(stamp_ovf), '0);
        check("R8 flag write 1 no effect", SNAP_W'(stamp_flag), 1);
        set_cal(5);
        drive_pin(1'b1);
        check("R7 ovf on flag set", SNAP_W'(stamp_ovf), 1);
        tick_once(); tick_once();
        check("R7 earlier capture kept", cap_all(), expect_snap);
        drive_pin(1'b0);
        clear_flags(2'b11);
        check("R8 write ones no effect", SNAP_W'({stamp_ovf, stamp_flag}), 2'b11);
        clear_flags(2'b00);
        check("R8 both cleared", SNAP_W'({stamp_ovf, stamp_flag}), '0);
    endtask

    // R9: clear colliding with detection and with arrival.
    task automatic t_race();
        set_cal(6);
        drive_pin(1'b1); drive_pin(1'b0);
        tick_once(); tick_once();
        check("R9 setup flag", SNAP_W'(stamp_flag), 1);
        set_cal(7);
        @(negedge clk) ts_pin = 1'b1;
        idle(2);
        clr_wr = 1'b1; clr_data = 2'b10;
        @(negedge clk) begin clr_wr = 1'b0; clr_data = 2'b11; end
        check("R9 ovf at detect collision", SNAP_W'(stamp_ovf), 1);
        check("R9 flag cleared by write", SNAP_W'(stamp_flag), '0);
        tick_once();
        expect_snap = {cal_date, cal_time, cal_ss};
        tick_once();
        check("R9 both set", SNAP_W'({stamp_ovf, stamp_flag}), 2'b11);
        check("R9 new capture", cap_all(), expect_snap);
        drive_pin(1'b0);
        clear_flags(2'b01);
        set_cal(8);
        drive_pin(1'b1);
        tick_once();
        @(negedge clk) begin tick = 1'b1; clr_wr = 1'b1; clr_data = 2'b10; end
        @(negedge clk) begin tick = 1'b0; clr_wr = 1'b0; clr_data = 2'b11; end
        check("R9 arrival beats clear", SNAP_W'(stamp_flag), 1);
        check("R9 arrival ovf", SNAP_W'(stamp_ovf), 1);
        check("R9 arrival keeps capture", cap_all(), expect_snap);
        drive_pin(1'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        idle(4);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        t_basic();
        t_polarity();
        t_enable();
        t_overflow();
        t_race();
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule